// File: doc/BRIEF.md
# Wait-state memory slave

This block is a word-wide memory that sits behind a shared bus and serves one single-word read or write per request. It owns a fixed, contiguous byte-address window and publishes the first and last byte of that window as constant outputs. The bus uses these outputs to route requests and to detect overlapping windows.

The response is a two-bit status that is worked out again in every cycle. While select is low the status is idle. A request that cannot be served gets an error in the cycle it is presented. This covers an address that is not word aligned, an address outside the window, and a write to an instance built read-only. A serviceable request gets a parameterised number of wait cycles and then ok. The bus holds the same request for as long as it sees wait. The access takes effect only in the ok cycle: a write is stored on that edge, and read data appears only in that cycle.

The wait counter restarts whenever a new request shows up. A new request is a rise of select, a change of address or direction, or any cycle that follows a finished access. Dropping select abandons the access in progress. With zero wait states the slave answers ok in the same cycle it is selected.

Top module: `wait_mem_slave`

## Requirements
- R1: `win_first` equals BASE_ADDR and `win_last` equals BASE_ADDR + 4*DEPTH - 1. Both are inclusive byte addresses and never change.
- R2: While `sel` is 0, `resp` is IDLE (2'b00) and `rdata` is zero.
- R3: A valid request held unchanged gives exactly WAIT_STATES cycles of WAIT (2'b01), then one cycle of OK (2'b10).
- R4: Changing `addr` or `wr` while a request is being waited on restarts the full WAIT_STATES count for the new request.
- R5: Dropping `sel` during the wait cycles abandons the access. A later select of the same request waits the full WAIT_STATES again, and a write that was abandoned leaves the memory unchanged.
- R6: With `sel` high, an address whose bits [1:0] are not 2'b00, or an address outside [win_first, win_last], gives ERR (2'b11) in that same cycle, with no wait cycles.
- R7: When READ_ONLY is 1, every selected write gives ERR at once and leaves the memory unchanged. Reads are still served.
- R8: A write stores `wdata` at word (addr - BASE_ADDR)/4 in its OK cycle. A later read of that word returns the value in its own OK cycle.
- R9: `rdata` is zero in every cycle except the OK cycle of a read.
- R10: If the same request is still presented in the cycle after OK, it counts as a new access and gets the full wait count again.
- R11: With WAIT_STATES = 0, every valid request answers OK in the cycle it is presented, including repeated cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Request present on the bus |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address of the word |
| wdata | input | DATA_W | Data to store on a write |
| rdata | output | DATA_W | Read data, non-zero only in the OK cycle of a read |
| resp | output | 2 | 00 idle, 01 wait, 10 ok, 11 error |
| win_first | output | ADDR_W | First byte address of the window |
| win_last | output | ADDR_W | Last byte address of the window (inclusive) |

## Verification
The checker assumes the bus protocol is followed. After a WAIT, the bus either keeps the same address and direction, changes them, or drops select. The stimulus is built on this rule. Each request is held for a random number of cycles, from an early abandon up to several back-to-back repeats past OK. An idle cycle is forced between two identical requests whenever the first may have been cut short, so every wait run the checker measures belongs to a single access. Random addresses are mostly aligned and inside the window, with a share that is misaligned or outside it, so the error checks are exercised under the same bus rule.

// File: rtl/wms_pkg.sv
`timescale 1ns/1ps
package wms_pkg;
  typedef enum logic [1:0] {
    RSP_IDLE = 2'b00,
    RSP_WAIT = 2'b01,
    RSP_OK   = 2'b10,
    RSP_ERR  = 2'b11
  } wms_resp_e;
endpackage

// File: rtl/wms_decode.sv
`timescale 1ns/1ps
module wms_decode #(
  parameter int                ADDR_W    = 32,
  parameter int                DEPTH     = 64,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_0400,
  localparam int               IDX_W     = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_window,
  output logic              aligned,
  output logic [IDX_W-1:0]  word_idx
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(4*DEPTH - 1);

  logic [ADDR_W-1:0] offset;
  logic              unused_off;

  assign offset     = addr - BASE_ADDR;
  assign in_window  = (addr >= BASE_ADDR) && (addr <= LAST_ADDR);
  assign aligned    = (addr[1:0] == 2'b00);
  assign word_idx   = offset[IDX_W+1:2];
  assign unused_off = ^{offset[ADDR_W-1:IDX_W+2], offset[1:0]};
endmodule

// File: rtl/wms_wait_ctrl.sv
`timescale 1ns/1ps
module wms_wait_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int WAIT_STATES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              done,
  output logic              waiting
);
  generate
    if (WAIT_STATES == 0) begin : g_nowait
      logic unused_w0;
      assign unused_w0 = ^{clk, rst, sel, wr, addr, done};
      assign waiting   = 1'b0;
    end else begin : g_wait
      localparam int CW = $clog2(WAIT_STATES + 1);
      localparam logic [CW-1:0] RELOAD = CW'(WAIT_STATES);

      logic [CW-1:0]     cnt_q, remaining;
      logic              sel_q, wr_q, done_q, fresh;
      logic [ADDR_W-1:0] addr_q;

      assign fresh     = sel && (!sel_q || done_q || (addr != addr_q) || (wr != wr_q));
      assign remaining = fresh ? RELOAD : cnt_q;
      assign waiting   = sel && (remaining != '0);

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q  <= '0;
          sel_q  <= 1'b0;
          wr_q   <= 1'b0;
          done_q <= 1'b0;
          addr_q <= '0;
        end else begin
          sel_q  <= sel;
          wr_q   <= wr;
          addr_q <= addr;
          done_q <= done;
          if (!sel || done)
            cnt_q <= '0;
          else
            cnt_q <= remaining - CW'(1);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wms_store.sv
`timescale 1ns/1ps
module wms_store #(
  parameter int  DATA_W     = 32,
  parameter int  DEPTH      = 64,
  parameter bit  ASYNC_READ = 1'b0,
  localparam int IDX_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  generate
    if (ASYNC_READ) begin : g_async
      assign rdata = mem[idx];
    end else begin : g_sync
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk) rd_q <= mem[idx];
      assign rdata = rd_q;
    end
  endgenerate
endmodule

// File: rtl/wait_mem_slave.sv
`timescale 1ns/1ps
module wait_mem_slave #(
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 32,
  parameter int                DEPTH       = 64,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 32'h0000_0400,
  parameter int                WAIT_STATES = 2,
  parameter bit                READ_ONLY   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        resp,
  output logic [ADDR_W-1:0] win_first,
  output logic [ADDR_W-1:0] win_last
);
  import wms_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);

  logic             in_window, aligned, waiting, done, reject;
  logic [IDX_W-1:0] word_idx;
  logic [DATA_W-1:0] mem_rd;
  wms_resp_e        rsp;

  wms_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .BASE_ADDR(BASE_ADDR)) u_decode (
    .addr(addr), .in_window(in_window), .aligned(aligned), .word_idx(word_idx)
  );

  wms_wait_ctrl #(.ADDR_W(ADDR_W), .WAIT_STATES(WAIT_STATES)) u_wait (
    .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr),
    .done(done), .waiting(waiting)
  );

  wms_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ASYNC_READ(WAIT_STATES == 0)) u_store (
    .clk(clk), .we(rsp == RSP_OK && wr), .idx(word_idx),
    .wdata(wdata), .rdata(mem_rd)
  );

  assign reject = !in_window || !aligned || (READ_ONLY && wr);

  always_comb begin
    if (!sel)         rsp = RSP_IDLE;
    else if (reject)  rsp = RSP_ERR;
    else if (waiting) rsp = RSP_WAIT;
    else              rsp = RSP_OK;
  end

  assign done      = (rsp == RSP_OK) || (rsp == RSP_ERR);
  assign resp      = rsp;
  assign rdata     = (rsp == RSP_OK && !wr) ? mem_rd : '0;
  assign win_first = BASE_ADDR;
  assign win_last  = BASE_ADDR + ADDR_W'(4*DEPTH - 1);
endmodule

// File: rtl/wms_checker.sv
`timescale 1ns/1ps
module wms_checker #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int WAIT_STATES = 2,
  parameter bit READ_ONLY   = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        resp,
  input logic [ADDR_W-1:0] win_first,
  input logic [ADDR_W-1:0] win_last
);
  logic              sel_q, wr_q, waited_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       run_q, run_now;

  assign run_now = (resp != 2'b01) ? 32'd0 :
                   (waited_q && sel_q && addr == addr_q && wr == wr_q) ? run_q + 32'd1 : 32'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0; wr_q <= 1'b0; waited_q <= 1'b0; addr_q <= '0; run_q <= '0;
    end else begin
      sel_q <= sel; wr_q <= wr; addr_q <= addr;
      waited_q <= (resp == 2'b01);
      run_q <= run_now;
    end
  end

  assert_window_fixed_R1: assert property (@(posedge clk) disable iff (rst)
    sel_q |-> ($stable(win_first) && $stable(win_last) && win_first <= win_last));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !sel |-> (resp == 2'b00 && rdata == '0));

  assert_wait_bound_R3: assert property (@(posedge clk) disable iff (rst)
    run_now <= 32'(WAIT_STATES));

  assert_wait_resolves_R3: assert property (@(posedge clk) disable iff (rst)
    (resp == 2'b01) ##1 (sel && addr == $past(addr) && wr == $past(wr))
      |-> (resp == 2'b01 || resp == 2'b10));

  assert_misaligned_err_R6: assert property (@(posedge clk) disable iff (rst)
    (sel && addr[1:0] != 2'b00) |-> resp == 2'b11);

  assert_readonly_err_R7: assert property (@(posedge clk) disable iff (rst)
    (READ_ONLY && sel && wr) |-> resp == 2'b11);

  assert_rdata_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (resp != 2'b10 || wr) |-> rdata == '0);
endmodule

bind wait_mem_slave wms_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_STATES(WAIT_STATES), .READ_ONLY(READ_ONLY)
) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr), .rdata(rdata),
  .resp(resp), .win_first(win_first), .win_last(win_last)
);

// File: tb/wait_mem_slave_test.sv
`timescale 1ns/1ps
module wait_mem_slave_test;
  localparam int          DEPTH = 64;
  localparam int          W     = 2;
  localparam logic [31:0] BASE  = 32'h0000_0400;
  localparam logic [31:0] LAST  = BASE + 32'(4*DEPTH - 1);

  logic        clk = 1'b0, rst = 1'b1, sel = 1'b0, wr = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rd_s, rd_f, rd_r, wf_s, wl_s, wf_f, wl_f, wf_r, wl_r;
  logic [1:0]  rs_s, rs_f, rs_r;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] model_s [DEPTH];
  logic [31:0] model_f [DEPTH];

  always #2 clk = ~clk;

  wait_mem_slave #(.DEPTH(DEPTH), .BASE_ADDR(BASE), .WAIT_STATES(W), .READ_ONLY(1'b0)) uut (
    .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rd_s), .resp(rs_s), .win_first(wf_s), .win_last(wl_s));
  wait_mem_slave #(.DEPTH(DEPTH), .BASE_ADDR(BASE), .WAIT_STATES(0), .READ_ONLY(1'b0)) uut_fast (
    .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rd_f), .resp(rs_f), .win_first(wf_f), .win_last(wl_f));
  wait_mem_slave #(.DEPTH(DEPTH), .BASE_ADDR(BASE), .WAIT_STATES(W), .READ_ONLY(1'b1)) uut_ro (
    .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rd_r), .resp(rs_r), .win_first(wf_r), .win_last(wl_r));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_bad(logic [31:0] a);
    return (a[1:0] != 2'b00) || (a < BASE) || (a > LAST);
  endfunction

  function automatic logic [1:0] exp_resp(int w, int k, bit bad, bit w_en, bit ro);
    if (bad || (w_en && ro)) return 2'b11;
    if ((k % (w + 1)) < w) return 2'b01;
    return 2'b10;
  endfunction

  function automatic int widx(logic [31:0] a);
    return int'((a - BASE) >> 2);
  endfunction

  // Hold one request for 'hold' cycles; cycle k of the hold is checked.
  task automatic run_access(bit w_en, logic [31:0] a, logic [31:0] d, int hold, string tag);
    bit bad = is_bad(a);
    for (int k = 0; k < hold; k++) begin
      logic [1:0] es, ef, er;
      @(negedge clk);
      sel = 1'b1; wr = w_en; addr = a; wdata = d;
      #1;
      es = exp_resp(W, k, bad, w_en, 1'b0);
      ef = exp_resp(0, k, bad, w_en, 1'b0);
      er = exp_resp(W, k, bad, w_en, 1'b1);
      check({tag, " resp main"}, 32'(rs_s), 32'(es));
      check({tag, " R11 resp fast"}, 32'(rs_f), 32'(ef));
      check({tag, " R7 resp read-only"}, 32'(rs_r), 32'(er));
      check({tag, " R9 R8 rdata main"}, rd_s, (es == 2'b10 && !w_en) ? model_s[widx(a)] : 32'h0);
      check({tag, " R11 rdata fast"}, rd_f, (ef == 2'b10 && !w_en) ? model_f[widx(a)] : 32'h0);
      check({tag, " R7 rdata read-only"}, rd_r, 32'h0);
      if (es == 2'b10 && w_en) model_s[widx(a)] = d;
      if (ef == 2'b10 && w_en) model_f[widx(a)] = d;
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    sel = 1'b0; wr = $urandom % 2; addr = BASE;
    #1;
    check("R2 idle resp main", 32'(rs_s), 32'h0);
    check("R2 idle rdata main", rd_s, 32'h0);
    check("R2 idle resp fast", 32'(rs_f), 32'h0);
    check("R2 idle resp read-only", 32'(rs_r), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa;
    bit          pw;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin model_s[i] = '0; model_f[i] = '0; end

    repeat (2) @(negedge clk);
    #1;
    check("R2 reset resp", 32'(rs_s), 32'h0);
    check("R1 first", wf_s, BASE);
    check("R1 last", wl_s, LAST);
    check("R1 last read-only", wl_r, LAST);
    @(negedge clk); rst = 1'b0;

    // R3, R8: basic write then read.
    run_access(1'b1, BASE + 32'h10, 32'hCAFE_0001, W + 1, "R3 R8 write");
    run_access(1'b0, BASE + 32'h10, 32'h0, W + 1, "R3 R8 read");
    // R4: address change mid-wait on an abandoned write.
    run_access(1'b1, BASE + 32'h20, 32'h1111_2222, 1, "R4 partial write");
    run_access(1'b0, BASE + 32'h24, 32'h0, W + 1, "R4 new address");
    run_access(1'b0, BASE + 32'h20, 32'h0, W + 1, "R4 R5 unwritten word");
    // R4: direction change.
    run_access(1'b0, BASE + 32'h30, 32'h0, W, "R4 partial read");
    run_access(1'b1, BASE + 32'h30, 32'h3333_4444, W + 1, "R4 direction change");
    // R5: select drop then same request.
    run_access(1'b1, BASE + 32'h40, 32'h5555_6666, 1, "R5 partial write");
    idle_cycle();
    run_access(1'b0, BASE + 32'h40, 32'h0, W + 1, "R5 restarted read");
    // R10: hold past OK.
    run_access(1'b0, BASE + 32'h30, 32'h0, 2*W + 3, "R10 back to back");
    // R6: error corners and window edges.
    run_access(1'b0, BASE + 32'h2, 32'h0, 2, "R6 misaligned");
    run_access(1'b1, LAST + 32'h1, 32'h9, 2, "R6 above window");
    run_access(1'b0, BASE - 32'h4, 32'h0, 2, "R6 below window");
    run_access(1'b1, LAST - 32'h3, 32'h7777_8888, W + 1, "R6 R8 last word write");
    run_access(1'b0, LAST - 32'h3, 32'h0, W + 1, "R6 R8 last word read");
    run_access(1'b1, BASE, 32'hABCD_0000, W + 1, "R8 first word write");
    idle_cycle();
    run_access(1'b0, BASE, 32'h0, W + 1, "R7 R8 first word read");

    pa = '0; pw = 1'b0;
    for (int it = 0; it < 400; it++) begin
      logic [31:0] a, d;
      bit          w_en;
      int          pick = $urandom % 10;
      int          hold = 1 + ($urandom % (W + 3));
      if (pick < 7)      a = BASE + 32'(4 * ($urandom % DEPTH));
      else if (pick < 8) a = BASE + 32'(4 * ($urandom % DEPTH)) + 32'(1 + $urandom % 3);
      else if (pick < 9) a = LAST + 32'(1 + $urandom % 64);
      else               a = BASE - 32'(1 + $urandom % 64);
      w_en = $urandom % 2;
      d    = $urandom;
      if ((a == pa && w_en == pw) || ($urandom % 4 == 0)) idle_cycle();
      run_access(w_en, a, d, hold, "random");
      pa = a; pw = w_en;
    end
    idle_cycle();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule